// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

An up-counting timer with one period (TOP) value and a parameterized number of compare channels. Each of these values exists twice: a live copy that the counter and the comparators use, and a shadow copy that software can fill at any moment. A pending shadow value moves into its live copy only at the hardware update point, which is the cycle in which the count equals TOP and is about to return to zero. Because of this, a period or compare change written through the shadow copy always takes effect at a clean period boundary.

Software reaches the block through a write-only register port: an enable, an address and a data word. Either copy may be written. Writing the live copy bypasses buffering and takes effect at once. A shadow copy that holds a value not yet consumed marks its slot as pending. While a slot is pending, further writes to that slot are refused and reported on an error pulse. A lock control can hold all pending copies back across any number of period boundaries. The block drives one-cycle compare-match outputs and a one-cycle wrap pulse at each TOP boundary.

Top module: `dbuf_timer`

## Requirements
- R1: After reset the count is 0, TOP is all ones, every compare value is 0, no slot is pending, the lock is released and `acc_err`, `wrap` are low.
- R2: The count rises by one every clock. In a cycle where count equals TOP, `wrap` is high for that cycle only and the next count is 0. A rollover from the all-ones value that is not a TOP match does not raise `wrap`.
- R3: Address map: 0 = TOP live, 1 = TOP shadow, 2 = lock set, 3 = lock clear, 4+2n = compare n live, 5+2n = compare n shadow. A live write to a slot that is not pending is visible on the live output in the cycle after the write.
- R4: A write to a shadow copy of a slot that is not pending marks that slot pending: its `*_bufv` and `*_busy` bits read 1 from the next cycle. The live value is unchanged.
- R5: A write to either copy of a pending slot is refused. `acc_err` is high for exactly the one cycle after that write. Neither the live value nor the pending shadow value changes.
- R6: At a `wrap` cycle with the lock released, every pending slot copies its shadow value into its live value and clears its pending bit on the next clock edge.
- R7: A write to address 2 sets the lock. While the lock is set, `wrap` cycles copy nothing and pending bits stay set.
- R8: A write to address 3 releases the lock. Values still pending are copied at the next `wrap` cycle.
- R9: If a live TOP write sets TOP below the current count, the counter runs up to the all-ones value, rolls to 0 with no `wrap` pulse, and then wraps at the new TOP.
- R10: A shadow TOP write made at any point in a period never lets the count pass the TOP in force. The new TOP governs from the period that follows the update.
- R11: `cmp_match[n]` is high exactly in cycles where the count equals the live compare value n. In an update cycle it uses the value held before the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address (map in R3) |
| wr_data | input | CNT_W | Register write data |
| count | output | CNT_W | Current counter value |
| top_val | output | CNT_W | Live TOP value |
| top_bufv | output | 1 | TOP shadow holds a pending value |
| top_busy | output | 1 | TOP slot busy, refuses writes |
| cmp_val | output | NUM_CH*CNT_W | Live compare values, channel n at bits n*CNT_W upward |
| cmp_bufv | output | NUM_CH | Compare shadow pending flags |
| cmp_busy | output | NUM_CH | Compare slot busy flags |
| lock_upd | output | 1 | Update lock state |
| acc_err | output | 1 | One-cycle pulse after a refused write |
| cmp_match | output | NUM_CH | Per-channel compare match |
| wrap | output | 1 | TOP match, update point |

## Verification
The bench lowers TOP directly below the running count and checks for the full run to the all-ones value with no `wrap` pulse. A design that wrapped at once, or pulsed `wrap` on the rollover, fails here. It then lowers TOP through the shadow copy partway through a period. A design that copied early would cut the period short, and the bench catches that by watching that the count never passes the old TOP. Refused writes are aimed at both copies of a pending slot. This exposes a design that overwrites the waiting shadow value or misses the error pulse. It also exposes one that lets the lock be ignored across several wraps. A compare channel is updated in the same cycle that its old value matches, which shows whether the match uses the stale value or the freshly copied one.

// File: rtl/dbuf_timer_pkg.sv
package dbuf_timer_pkg;
  // Fixed register addresses
  localparam int A_TOP_LIVE = 0;
  localparam int A_TOP_SHDW = 1;
  localparam int A_LOCK_SET = 2;
  localparam int A_LOCK_CLR = 3;
  localparam int A_CMP_BASE = 4;

  function automatic int cmp_live_addr(input int ch);
    return A_CMP_BASE + 2 * ch;
  endfunction

  function automatic int cmp_shdw_addr(input int ch);
    return A_CMP_BASE + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/dbuf_rst_sync.sv
module dbuf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/dbuf_counter.sv
module dbuf_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] top_q,
  output logic [CNT_W-1:0] count_q,
  output logic             at_top
);
  logic [CNT_W-1:0] count_d;

  // Continuous compare against TOP; no special case at all ones,
  // the natural width rollover handles an overshoot.
  always_comb begin
    at_top = (count_q == top_q);
    if (at_top) count_d = '0;
    else        count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/dbuf_slot.sv
module dbuf_slot #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_live,
  input  logic         wr_shdw,
  input  logic [W-1:0] wr_data,
  input  logic         upd,
  output logic [W-1:0] live_q,
  output logic [W-1:0] shdw_q,
  output logic         pend_q,
  output logic         reject
);
  logic [W-1:0] live_d;
  logic [W-1:0] shdw_d;
  logic         pend_d;
  logic         live_en;
  logic         shdw_en;
  logic         pend_en;

  always_comb begin
    live_d  = live_q;
    shdw_d  = wr_data;
    pend_d  = pend_q;
    live_en = 1'b0;
    shdw_en = 1'b0;
    pend_en = 1'b0;
    reject  = (wr_live | wr_shdw) & pend_q;
    if (pend_q) begin
      if (upd) begin
        live_d  = shdw_q;
        live_en = 1'b1;
        pend_d  = 1'b0;
        pend_en = 1'b1;
      end
    end else begin
      if (wr_live) begin
        live_d  = wr_data;
        live_en = 1'b1;
      end
      if (wr_shdw) begin
        shdw_en = 1'b1;
        pend_d  = 1'b1;
        pend_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= RST_VAL;
      shdw_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (live_en) live_q <= live_d;
      if (shdw_en) shdw_q <= shdw_d;
      if (pend_en) pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/dbuf_timer.sv
module dbuf_timer
  import dbuf_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [CNT_W-1:0]        wr_data,
  output logic [CNT_W-1:0]        count,
  output logic [CNT_W-1:0]        top_val,
  output logic                    top_bufv,
  output logic                    top_busy,
  output logic [NUM_CH*CNT_W-1:0] cmp_val,
  output logic [NUM_CH-1:0]       cmp_bufv,
  output logic [NUM_CH-1:0]       cmp_busy,
  output logic                    lock_upd,
  output logic                    acc_err,
  output logic [NUM_CH-1:0]       cmp_match,
  output logic                    wrap
);
  localparam logic [CNT_W-1:0] TOP_RST = {CNT_W{1'b1}};

  logic             rst_sync_n;
  logic             at_top;
  logic             upd;
  logic [CNT_W-1:0] top_shdw;
  logic             top_rej;
  logic [NUM_CH-1:0] cmp_rej;
  logic             lock_q;
  logic             lock_d;
  logic             lock_en;
  logic             err_d;

  dbuf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dbuf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .top_q   (top_val),
    .count_q (count),
    .at_top  (at_top)
  );

  assign upd  = at_top & ~lock_q;
  assign wrap = at_top;

  dbuf_slot #(.W(CNT_W), .RST_VAL(TOP_RST)) u_top (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_live (wr_en && (wr_addr == ADDR_W'(A_TOP_LIVE))),
    .wr_shdw (wr_en && (wr_addr == ADDR_W'(A_TOP_SHDW))),
    .wr_data (wr_data),
    .upd     (upd),
    .live_q  (top_val),
    .shdw_q  (top_shdw),
    .pend_q  (top_bufv),
    .reject  (top_rej)
  );
  assign top_busy = top_bufv;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    logic [CNT_W-1:0] shdw_unused;
    logic [CNT_W-1:0] live;

    dbuf_slot #(.W(CNT_W), .RST_VAL('0)) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_live (wr_en && (wr_addr == ADDR_W'(cmp_live_addr(ch)))),
      .wr_shdw (wr_en && (wr_addr == ADDR_W'(cmp_shdw_addr(ch)))),
      .wr_data (wr_data),
      .upd     (upd),
      .live_q  (live),
      .shdw_q  (shdw_unused),
      .pend_q  (cmp_bufv[ch]),
      .reject  (cmp_rej[ch])
    );

    assign cmp_val[ch*CNT_W +: CNT_W] = live;
    assign cmp_busy[ch]  = cmp_bufv[ch];
    assign cmp_match[ch] = (count == live);
  end

  // Lock control: set and clear are never refused
  always_comb begin
    lock_d  = lock_q;
    lock_en = 1'b0;
    if (wr_en && (wr_addr == ADDR_W'(A_LOCK_SET))) begin
      lock_d  = 1'b1;
      lock_en = 1'b1;
    end else if (wr_en && (wr_addr == ADDR_W'(A_LOCK_CLR))) begin
      lock_d  = 1'b0;
      lock_en = 1'b1;
    end
    err_d = top_rej | (|cmp_rej);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lock_q  <= 1'b0;
      acc_err <= 1'b0;
    end else begin
      if (lock_en) lock_q <= lock_d;
      acc_err <= err_d;
    end
  end

  assign lock_upd = lock_q;
endmodule

// File: rtl/dbuf_timer_chk.sv
module dbuf_timer_chk
  import dbuf_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  top_val,
  input logic              top_bufv,
  input logic              lock_upd,
  input logic              acc_err,
  input logic              wrap
);
  logic wr_top_live;
  logic wr_top_any;
  logic will_copy;
  assign wr_top_live = wr_en && (wr_addr == ADDR_W'(A_TOP_LIVE));
  assign wr_top_any  = wr_en && ((wr_addr == ADDR_W'(A_TOP_LIVE)) ||
                                 (wr_addr == ADDR_W'(A_TOP_SHDW)));
  assign will_copy   = wrap && !lock_upd;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> count == CNT_W'($past(count) + 1'b1));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);

  p_live_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_top_live && !top_bufv |=> top_val == $past(wr_data));

  p_shadow_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr == ADDR_W'(A_TOP_SHDW)) && !top_bufv |=> top_bufv);

  p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_top_any && top_bufv && !will_copy |=> acc_err && $stable(top_val));

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(wr_en));

  p_copy_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    will_copy && top_bufv |=> !top_bufv);

  p_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_upd && top_bufv |=> top_bufv);
endmodule

bind dbuf_timer dbuf_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .count    (count),
  .top_val  (top_val),
  .top_bufv (top_bufv),
  .lock_upd (lock_upd),
  .acc_err  (acc_err),
  .wrap     (wrap)
);

// File: tb/dbuf_timer_test.sv
module dbuf_timer_test;
  localparam int CNT_W  = 8;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 4;

  logic                    clk;
  logic                    rst_n;
  logic                    wr_en;
  logic [ADDR_W-1:0]       wr_addr;
  logic [CNT_W-1:0]        wr_data;
  logic [CNT_W-1:0]        count;
  logic [CNT_W-1:0]        top_val;
  logic                    top_bufv;
  logic                    top_busy;
  logic [NUM_CH*CNT_W-1:0] cmp_val;
  logic [NUM_CH-1:0]       cmp_bufv;
  logic [NUM_CH-1:0]       cmp_busy;
  logic                    lock_upd;
  logic                    acc_err;
  logic [NUM_CH-1:0]       cmp_match;
  logic                    wrap;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  dbuf_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .top_val(top_val),
    .top_bufv(top_bufv), .top_busy(top_busy), .cmp_val(cmp_val),
    .cmp_bufv(cmp_bufv), .cmp_busy(cmp_busy), .lock_upd(lock_upd),
    .acc_err(acc_err), .cmp_match(cmp_match), .wrap(wrap)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Returns at a negedge where count == v (checks current sample first)
  task automatic wait_count(input int v);
    for (int i = 0; i < 600; i++) begin
      if (int'(count) == v) return;
      @(negedge clk);
    end
    chk("R2 wait_count timeout", 0, 1);
  endtask

  task automatic wait_wrap();
    for (int i = 0; i < 600; i++) begin
      if (wrap) return;
      @(negedge clk);
    end
    chk("R2 wait_wrap timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 top", int'(top_val), 255);
    chk("R1 cmp", int'(cmp_val), 0);
    chk("R1 bufv", int'({top_bufv, cmp_bufv}), 0);
    chk("R1 lock", int'(lock_upd), 0);
    chk("R1 acc_err", int'(acc_err), 0);
  endtask

  task automatic t_direct_top();
    wr(0, 9);
    chk("R3 live top", int'(top_val), 9);
    chk("R3 no pend", int'(top_bufv), 0);
    wait_count(9);
    chk("R2 wrap at top", int'(wrap), 1);
    @(negedge clk);
    chk("R2 count to 0", int'(count), 0);
    chk("R2 wrap one cycle", int'(wrap), 0);
  endtask

  task automatic t_buffered_top();
    int maxc;
    wait_count(3);
    wr(1, 5);
    chk("R4 bufv", int'(top_bufv), 1);
    chk("R4 busy", int'(top_busy), 1);
    chk("R4 live kept", int'(top_val), 9);
    maxc = 0;
    for (int i = 0; i < 40 && !wrap; i++) begin
      if (int'(count) > maxc) maxc = int'(count);
      @(negedge clk);
    end
    chk("R10 count at wrap", int'(count), 9);
    chk("R10 no overshoot", (maxc <= 9) ? 1 : 0, 1);
    @(negedge clk);
    chk("R6 copied", int'(top_val), 5);
    chk("R6 bufv cleared", int'(top_bufv), 0);
    wait_count(5);
    chk("R6 new top wraps", int'(wrap), 1);
  endtask

  task automatic t_reject_lock();
    wr(2, 0);
    chk("R7 lock set", int'(lock_upd), 1);
    wr(1, 20);
    chk("R4 pend", int'(top_bufv), 1);
    wr(0, 3);
    chk("R5 err live", int'(acc_err), 1);
    chk("R5 live kept", int'(top_val), 5);
    @(negedge clk);
    chk("R5 err one cycle", int'(acc_err), 0);
    wr(1, 30);
    chk("R5 err shadow", int'(acc_err), 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      wait_wrap();
      @(negedge clk);
      chk("R7 no copy", int'(top_val), 5);
      chk("R7 still pend", int'(top_bufv), 1);
    end
    wr(3, 0);
    chk("R8 lock clear", int'(lock_upd), 0);
    wait_wrap();
    @(negedge clk);
    chk("R8 copied after release", int'(top_val), 20);
    chk("R5 shadow kept first", int'(top_val), 20);
    chk("R8 bufv cleared", int'(top_bufv), 0);
  endtask

  task automatic t_shrink_direct();
    int prev;
    int seen_wrap;
    wait_count(15);
    wr(0, 10);
    chk("R9 top lowered", int'(top_val), 10);
    seen_wrap = 0;
    prev = int'(count);
    for (int i = 0; i < 400 && count != 0; i++) begin
      if (wrap) seen_wrap = 1;
      prev = int'(count);
      @(negedge clk);
    end
    chk("R9 no wrap on rollover", seen_wrap, 0);
    chk("R9 rolled from max", prev, 255);
    wait_wrap();
    chk("R9 wraps at new top", int'(count), 10);
  endtask

  task automatic t_shrink_buffered();
    int maxc;
    @(negedge clk);
    wr(0, 40);
    wait_count(30);
    wr(1, 12);
    maxc = 0;
    for (int i = 0; i < 80 && !wrap; i++) begin
      if (int'(count) > maxc) maxc = int'(count);
      @(negedge clk);
    end
    chk("R10 old top held", int'(count), 40);
    chk("R10 no early cut", (maxc <= 40) ? 1 : 0, 1);
    @(negedge clk);
    chk("R10 new top live", int'(top_val), 12);
    wait_wrap();
    chk("R10 new period", int'(count), 12);
  endtask

  task automatic t_compare();
    int hits;
    wr(4, 7);
    wr(6, 12);
    @(negedge clk);
    wait_wrap();
    @(negedge clk);
    hits = 0;
    for (int i = 0; i < 13; i++) begin
      if (cmp_match[0] != (count == 8'd7)) hits = hits + 100;
      if (cmp_match[0]) hits++;
      @(negedge clk);
    end
    chk("R11 ch0 single match", hits, 1);
    wr(4, 12);
    wr(5, 3);
    chk("R4 cmp busy", int'(cmp_busy[0]), 1);
    wr(7, 5);
    wr(7, 6);
    chk("R5 cmp err", int'(acc_err), 1);
    wait_wrap();
    chk("R11 old value matches", int'(cmp_match[0]), 1);
    chk("R11 ch1 old match", int'(cmp_match[1]), 1);
    @(negedge clk);
    chk("R6 cmp0 copied", int'(cmp_val[0 +: CNT_W]), 3);
    chk("R5 cmp1 first kept", int'(cmp_val[CNT_W +: CNT_W]), 5);
    chk("R6 cmp bufv cleared", int'(cmp_bufv), 0);
    chk("R11 no match at 0", int'(cmp_match[0]), 0);
    wait_count(3);
    chk("R11 new value matches", int'(cmp_match[0]), 1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // count may have started; reset state sampled once under reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_direct_top();
    t_buffered_top();
    t_reject_lock();
    t_shrink_direct();
    t_shrink_buffered();
    t_compare();
    finish_run();
  end
endmodule